// File: doc/BRIEF.md
# Mailbox Command Sequencer

This engine runs one complete request/reply exchange with a co-processor on behalf of the host. It takes a command index and a start pulse. Over a simple request/acknowledge register bus it first waits for the co-processor's reply mailbox to read empty. It then writes a five-word message into the shared message RAM and rings the doorbell mailbox. It polls for a nonzero reply code, copies the five reply words back and releases the reply mailbox. Finally it checks that the reply's checksum word matches the sum of the other four words.

The result is a one-cycle done pulse, a 32-bit status word and the five reply words. A success is reported as 0x1. An error sets bit 31 together with a single reason bit. Every wait on the mailbox is bounded by a poll limit, and polls are separated by a programmable number of idle cycles. The co-processor itself is not part of the block, and neither is any reading of the reply payload.

Top module: `mbox_cmd_seq`

## Requirements
- R1: A start in idle with a command index of 3 or more (index field 3 bits wide) is rejected: in the next cycle done_o pulses with status 0x80000002, the reply reads zero, and no bus request is made.
- R2: For a valid index the engine first reads the reply mailbox at byte offset 0x14, repeating until it reads zero, and makes no write before that zero is seen.
- R3: If POLL_MAX reads of offset 0x14 all return nonzero, the run ends with status 0x80000010 and no write of any kind: no message word, no doorbell and no mailbox release.
- R4: After the idle check, the five message words are written in order, word i at byte offset 0x100 + 4*i. For index 0 the words (header, command, argument count, argument, checksum) are (1,1,1,1,4), for index 1 they are (1,2,1,1,5), and for index 2 they are (1,2,1,2,6).
- R5: After the fifth message word, the value 1 is written to the doorbell mailbox at offset 0x10, exactly once.
- R6: The engine then reads offset 0x14 until it is nonzero, and then reads the five words from 0x100 + 4*i. Word i appears on reply_o bits [32*i+31 : 32*i].
- R7: Between two successive mailbox polls of one wait, the bus request stays low for at least POLL_GAP cycles.
- R8: If POLL_MAX reply polls all read zero, no message word is read back, reply_o reads all zero, and the status is 0x80000010.
- R9: Every run that reached the doorbell ends with exactly one write of 0 to offset 0x14, and this is its last bus access, on success and on timeout alike.
- R10: When reply word 4 differs from the 32-bit sum of reply words 0 to 3, the status is 0x80000004.
- R11: When the reply checksum holds, the status equals the nonzero value read from the reply mailbox: 0x1 for success, or the co-processor's own error code.
- R12: done_o is high for one cycle per run and is low after reset. status_o keeps its value until the next done.
- R13: A start that arrives while a run is in progress is ignored. The running command completes with its own message, and there is exactly one done.
- R14: A bus request, once raised, stays high with stable address, write flag and write data until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only in idle |
| cmd_idx_i | input | IDX_W | Command index |
| bus_req_o | output | 1 | Bus request, held until acknowledged |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Byte offset in the co-processor block |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Access complete; read data valid with it |
| bus_rdata_i | input | 32 | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 32 | Result code of the last run |
| reply_o | output | 160 | Five reply words, word 0 in the low bits |

## Verification
A rejected index is due one cycle after the start edge. The bench drives the start at a falling edge and checks done_o and status_o at the very next falling edge, and checks that done_o is low again one cycle later. For accepted commands the run length depends on the co-processor's answer, so the bench waits for the done pulse on falling edges. At that edge it reads status_o and reply_o. It then compares the message, doorbell, release and poll counts, which the responder model recorded at each acknowledged access, against values worked out from the configured busy and delay counts. Poll spacing is measured in cycles between the first request cycles of successive polls.

// File: rtl/mbox_seq_pkg.sv
package mbox_seq_pkg;

  localparam int WORD_W    = 32;
  localparam int MSG_WORDS = 5;
  localparam int NUM_CMDS  = 3;

  localparam logic [31:0] TOCP_OFF   = 32'h10;
  localparam logic [31:0] TOHOST_OFF = 32'h14;
  localparam logic [31:0] MSG_BASE   = 32'h100;

  localparam logic [31:0] ST_OK      = 32'h0000_0001;
  localparam logic [31:0] ST_ERR_BIT = 32'h8000_0000;
  localparam logic [31:0] ST_INVAL   = ST_ERR_BIT | 32'h2;
  localparam logic [31:0] ST_CHKSUM  = ST_ERR_BIT | 32'h4;
  localparam logic [31:0] ST_TIMEOUT = ST_ERR_BIT | 32'h10;

  typedef enum logic [3:0] {
    S_IDLE, S_PI, S_PW, S_PG, S_MI, S_MW, S_DI, S_DW,
    S_RI, S_RW, S_RG, S_BI, S_BW, S_CI, S_CW, S_FIN
  } seq_state_e;

  // Message word w of command c: header 1, opcode, argc 1, argument, sum.
  function automatic logic [31:0] cmd_word(input logic [1:0] c, input logic [2:0] w);
    logic [31:0] op, arg;
    op  = (c == 2'd0) ? 32'd1 : 32'd2;
    arg = (c == 2'd2) ? 32'd2 : 32'd1;
    case (w)
      3'd0:    return 32'd1;
      3'd1:    return op;
      3'd2:    return 32'd1;
      3'd3:    return arg;
      default: return 32'd1 + op + 32'd1 + arg;
    endcase
  endfunction

  function automatic logic [31:0] msg_off(input logic [2:0] w);
    return MSG_BASE + {27'd0, w, 2'b00};
  endfunction

  // Sum of the first four words of a flattened message.
  function automatic logic [31:0] head_sum(input logic [WORD_W*MSG_WORDS-1:0] f);
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < MSG_WORDS - 1; i++) s = s + f[i*WORD_W +: WORD_W];
    return s;
  endfunction

endpackage

// File: rtl/mbox_poll_ctl.sv
module mbox_poll_ctl #(
  parameter int POLL_MAX = 1000,
  parameter int POLL_GAP = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        miss_i,
  output logic        last_o,
  output logic        gap_done_o,
  output logic [31:0] cnt_o
);
  localparam int CNT_W = (POLL_MAX < 2) ? 1 : $clog2(POLL_MAX + 1);
  localparam int GAP_W = (POLL_GAP < 2) ? 1 : $clog2(POLL_GAP + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      gap_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      gap_q <= '0;
    end else if (miss_i) begin
      cnt_q <= cnt_q + 1'b1;
      gap_q <= GAP_W'(POLL_GAP);
    end else if (gap_q != '0) begin
      gap_q <= gap_q - 1'b1;
    end
  end

  assign last_o     = (cnt_q == CNT_W'(POLL_MAX - 1));
  assign gap_done_o = (gap_q == '0);
  assign cnt_o      = 32'(cnt_q);
endmodule

// File: rtl/mbox_bus_port.sv
module mbox_bus_port #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              fin_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_req_o   <= 1'b0;
      bus_we_o    <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
    end else if (go_i) begin
      bus_req_o   <= 1'b1;
      bus_we_o    <= we_i;
      bus_addr_o  <= addr_i;
      bus_wdata_o <= wdata_i;
    end else if (bus_req_o && bus_ack_i) begin
      bus_req_o <= 1'b0;
    end
  end

  assign fin_o   = bus_req_o & bus_ack_i;
  assign rdata_o = bus_rdata_i;
endmodule

// File: rtl/mbox_reply_store.sv
module mbox_reply_store
  import mbox_seq_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr_i,
  input  logic                        wr_i,
  input  logic [2:0]                  idx_i,
  input  logic [WORD_W-1:0]           data_i,
  output logic [WORD_W*MSG_WORDS-1:0] words_o,
  output logic                        sum_ok_o
);
  for (genvar g = 0; g < MSG_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] w_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            w_q <= '0;
      else if (clr_i)                        w_q <= '0;
      else if (wr_i && idx_i == 3'(g))       w_q <= data_i;
    end
    assign words_o[g*WORD_W +: WORD_W] = w_q;
  end

  assign sum_ok_o = (head_sum(words_o) == words_o[(MSG_WORDS-1)*WORD_W +: WORD_W]);
endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
  import mbox_seq_pkg::*;
#(
  parameter int POLL_MAX = 1000,
  parameter int POLL_GAP = 8,
  parameter int ADDR_W   = 12,
  parameter int IDX_W    = 3   // at least 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [IDX_W-1:0]            cmd_idx_i,
  output logic                        bus_req_o,
  output logic                        bus_we_o,
  output logic [ADDR_W-1:0]           bus_addr_o,
  output logic [WORD_W-1:0]           bus_wdata_o,
  input  logic                        bus_ack_i,
  input  logic [WORD_W-1:0]           bus_rdata_i,
  output logic                        done_o,
  output logic [WORD_W-1:0]           status_o,
  output logic [WORD_W*MSG_WORDS-1:0] reply_o
);
  localparam logic [2:0] LAST_W = 3'(MSG_WORDS - 1);

  seq_state_e        state_q;
  logic [1:0]        cmd_q;
  logic [2:0]        widx_q;
  logic [WORD_W-1:0] resp_q;
  logic              tmo_q;
  logic              idle_seen_q;
  logic              done_q;
  logic [WORD_W-1:0] status_q;

  // Named internal events
  logic              idle_w, accept_w, reject_w, idle_seen_w;
  logic [1:0]        cmd_w;
  logic              fin_w, miss_w, last_w, gap_done_w, clr_poll_w, store_wr_w, sum_ok_w;
  logic [WORD_W-1:0] rdata_w;
  logic [31:0]       poll_cnt_w;

  logic              go_w, go_we_w;
  logic [ADDR_W-1:0] go_addr_w;
  logic [WORD_W-1:0] go_wdata_w;

  assign idle_w      = (state_q == S_IDLE);
  assign accept_w    = idle_w & start_i;
  assign reject_w    = accept_w & (cmd_idx_i >= IDX_W'(NUM_CMDS));
  assign idle_seen_w = idle_seen_q;
  assign cmd_w       = cmd_q;

  assign miss_w = ((state_q == S_PW) & fin_w & (rdata_w != '0)) |
                  ((state_q == S_RW) & fin_w & (rdata_w == '0));
  assign clr_poll_w = accept_w | ((state_q == S_DW) & fin_w);
  assign store_wr_w = (state_q == S_BW) & fin_w;

  always_comb begin
    go_w       = 1'b0;
    go_we_w    = 1'b0;
    go_addr_w  = '0;
    go_wdata_w = '0;
    unique case (state_q)
      S_PI, S_RI: begin
        go_w      = 1'b1;
        go_addr_w = ADDR_W'(TOHOST_OFF);
      end
      S_MI: begin
        go_w       = 1'b1;
        go_we_w    = 1'b1;
        go_addr_w  = ADDR_W'(msg_off(widx_q));
        go_wdata_w = cmd_word(cmd_q, widx_q);
      end
      S_DI: begin
        go_w       = 1'b1;
        go_we_w    = 1'b1;
        go_addr_w  = ADDR_W'(TOCP_OFF);
        go_wdata_w = 32'd1;
      end
      S_BI: begin
        go_w      = 1'b1;
        go_addr_w = ADDR_W'(msg_off(widx_q));
      end
      S_CI: begin
        go_w      = 1'b1;
        go_we_w   = 1'b1;
        go_addr_w = ADDR_W'(TOHOST_OFF);
      end
      default: ;
    endcase
  end

  mbox_bus_port #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .go_i(go_w), .we_i(go_we_w), .addr_i(go_addr_w), .wdata_i(go_wdata_w),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i),
    .fin_o(fin_w), .rdata_o(rdata_w)
  );

  mbox_poll_ctl #(.POLL_MAX(POLL_MAX), .POLL_GAP(POLL_GAP)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_poll_w), .miss_i(miss_w),
    .last_o(last_w), .gap_done_o(gap_done_w), .cnt_o(poll_cnt_w)
  );

  mbox_reply_store u_store (
    .clk(clk), .rst_n(rst_n), .clr_i(accept_w), .wr_i(store_wr_w),
    .idx_i(widx_q), .data_i(rdata_w), .words_o(reply_o), .sum_ok_o(sum_ok_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      cmd_q       <= '0;
      widx_q      <= '0;
      resp_q      <= '0;
      tmo_q       <= 1'b0;
      idle_seen_q <= 1'b0;
      done_q      <= 1'b0;
      status_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept_w) begin
          if (reject_w) begin
            status_q <= ST_INVAL;
            done_q   <= 1'b1;
          end else begin
            cmd_q       <= cmd_idx_i[1:0];
            widx_q      <= '0;
            resp_q      <= '0;
            tmo_q       <= 1'b0;
            idle_seen_q <= 1'b0;
            state_q     <= S_PI;
          end
        end
        S_PI: state_q <= S_PW;
        S_PW: if (fin_w) begin
          if (rdata_w == '0) begin
            idle_seen_q <= 1'b1;
            widx_q      <= '0;
            state_q     <= S_MI;
          end else if (last_w) begin
            tmo_q   <= 1'b1;
            state_q <= S_FIN;
          end else begin
            state_q <= S_PG;
          end
        end
        S_PG: if (gap_done_w) state_q <= S_PI;
        S_MI: state_q <= S_MW;
        S_MW: if (fin_w) begin
          if (widx_q == LAST_W) state_q <= S_DI;
          else begin
            widx_q  <= widx_q + 1'b1;
            state_q <= S_MI;
          end
        end
        S_DI: state_q <= S_DW;
        S_DW: if (fin_w) state_q <= S_RI;
        S_RI: state_q <= S_RW;
        S_RW: if (fin_w) begin
          if (rdata_w != '0) begin
            resp_q  <= rdata_w;
            widx_q  <= '0;
            state_q <= S_BI;
          end else if (last_w) begin
            tmo_q   <= 1'b1;
            state_q <= S_CI;
          end else begin
            state_q <= S_RG;
          end
        end
        S_RG: if (gap_done_w) state_q <= S_RI;
        S_BI: state_q <= S_BW;
        S_BW: if (fin_w) begin
          if (widx_q == LAST_W) state_q <= S_CI;
          else begin
            widx_q  <= widx_q + 1'b1;
            state_q <= S_BI;
          end
        end
        S_CI: state_q <= S_CW;
        S_CW: if (fin_w) state_q <= S_FIN;
        S_FIN: begin
          if (tmo_q)          status_q <= ST_TIMEOUT;
          else if (!sum_ok_w) status_q <= ST_CHKSUM;
          else                status_q <= resp_q;
          done_q  <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign done_o   = done_q;
  assign status_o = status_q;
endmodule

// File: rtl/mbox_seq_chk.sv
module mbox_seq_chk #(
  parameter int POLL_MAX = 1000,
  parameter int ADDR_W   = 12,
  parameter int IDX_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [IDX_W-1:0]  cmd_idx_i,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [31:0]       bus_wdata_o,
  input logic              bus_ack_i,
  input logic              done_o,
  input logic [31:0]       status_o,
  input logic              idle_w,
  input logic              idle_seen_w,
  input logic [1:0]        cmd_w,
  input logic [31:0]       poll_cnt_w
);
  p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idle_w && start_i && (cmd_idx_i >= IDX_W'(3)) |=> done_o && status_o == 32'h8000_0002 && !bus_req_o);

  p_write_after_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && bus_we_o |-> idle_seen_w);

  p_poll_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt_w <= 32'(POLL_MAX));

  p_doorbell_val_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && bus_we_o && bus_addr_o == ADDR_W'(32'h10) |-> bus_wdata_o == 32'd1);

  p_release_val_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && bus_we_o && bus_addr_o == ADDR_W'(32'h14) |-> bus_wdata_o == 32'd0);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_busy_ignore_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_w && start_i |=> $stable(cmd_w));

  p_bus_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o));
endmodule

bind mbox_cmd_seq mbox_seq_chk #(.POLL_MAX(POLL_MAX), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_idx_i(cmd_idx_i),
  .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
  .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .done_o(done_o),
  .status_o(status_o), .idle_w(idle_w), .idle_seen_w(idle_seen_w),
  .cmd_w(cmd_w), .poll_cnt_w(poll_cnt_w)
);

// File: tb/mbox_cmd_seq_bench.sv
module mbox_cmd_seq_bench;
  localparam int PMAX = 1000;
  localparam int PGAP = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [2:0]   idx = '0;
  logic         bus_req, bus_we, bus_ack;
  logic [11:0]  bus_addr;
  logic [31:0]  bus_wdata, bus_rdata;
  logic         done;
  logic [31:0]  status;
  logic [159:0] reply;

  int n_checks = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  mbox_cmd_seq #(.POLL_MAX(PMAX), .POLL_GAP(PGAP)) u_mbox_cmd_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cmd_idx_i(idx),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
    .done_o(done), .status_o(status), .reply_o(reply)
  );

  // Responder configuration (driven by the test tasks)
  logic        clr_stats = 1'b0;
  int          cfg_busy = 0;
  int          cfg_wait = 0;
  logic        cfg_never = 1'b0;
  logic        cfg_corrupt = 1'b0;
  logic [31:0] cfg_code = 32'd1;
  logic [31:0] cfg_pay = 32'h0;

  // Responder state and statistics
  logic        ack_r, pend;
  logic [31:0] rdata_r;
  logic [31:0] host_msg [5];
  logic [31:0] rep [5];
  int busy_left, wait_left, n_acc, n_msg_wr, n_door, n_clr, n_rd, n_done, n_readback;
  int cyc, prev_poll, min_gap;
  logic have_prev, last_we;
  logic [11:0] last_addr;
  logic [31:0] last_wd;

  assign bus_ack   = ack_r;
  assign bus_rdata = rdata_r;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n || clr_stats) begin
      ack_r <= 1'b0; rdata_r <= '0; pend <= 1'b0;
      busy_left <= cfg_busy; wait_left <= cfg_wait;
      n_acc <= 0; n_msg_wr <= 0; n_door <= 0; n_clr <= 0; n_rd <= 0; n_done <= 0; n_readback <= 0;
      have_prev <= 1'b0; min_gap <= 1000000; prev_poll <= 0;
      last_we <= 1'b0; last_addr <= '0; last_wd <= '0;
      for (int i = 0; i < 5; i++) begin host_msg[i] <= '0; rep[i] <= '0; end
    end else begin
      if (done) n_done <= n_done + 1;
      ack_r <= bus_req && !ack_r;
      if (bus_req && !ack_r) begin
        n_acc <= n_acc + 1; last_we <= bus_we; last_addr <= bus_addr; last_wd <= bus_wdata;
        if (bus_we) begin
          if (bus_addr >= 12'h100 && bus_addr < 12'h114) begin
            n_msg_wr <= n_msg_wr + 1;
            host_msg[(bus_addr - 12'h100) >> 2] <= bus_wdata;
          end else if (bus_addr == 12'h010) begin
            n_door <= n_door + 1; pend <= 1'b1;
          end else if (bus_addr == 12'h014) begin
            n_clr <= n_clr + 1;
          end
        end else if (bus_addr == 12'h014) begin
          n_rd <= n_rd + 1;
          if (pend) begin
            if (have_prev && (cyc - prev_poll) < min_gap) min_gap <= cyc - prev_poll;
            prev_poll <= cyc; have_prev <= 1'b1;
            if (wait_left > 0) begin
              wait_left <= wait_left - 1; rdata_r <= '0;
            end else if (cfg_never) begin
              rdata_r <= '0;
            end else begin
              rdata_r <= cfg_code;
              rep[0] <= 32'd2; rep[1] <= host_msg[1]; rep[2] <= 32'd1; rep[3] <= cfg_pay;
              rep[4] <= 32'd2 + host_msg[1] + 32'd1 + cfg_pay + (cfg_corrupt ? 32'd1 : 32'd0);
            end
          end else if (busy_left > 0) begin
            busy_left <= busy_left - 1; rdata_r <= 32'h7;
          end else begin
            rdata_r <= '0;
          end
        end else begin
          n_readback <= n_readback + 1;
          rdata_r <= rep[(bus_addr - 12'h100) >> 2];
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setup(input int busy, input int wt, input logic never, input logic corrupt,
                       input logic [31:0] code, input logic [31:0] pay);
    cfg_busy = busy; cfg_wait = wt; cfg_never = never; cfg_corrupt = corrupt;
    cfg_code = code; cfg_pay = pay;
    @(negedge clk); clr_stats = 1'b1;
    @(negedge clk); clr_stats = 1'b0;
  endtask

  task automatic pulse_start(input logic [2:0] i);
    @(negedge clk); start = 1'b1; idx = i;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int k = 0;
    while (!done && k < 40000) begin @(negedge clk); k++; end
    if (!done) check({tag, " done timeout"}, 32'd0, 32'd1);
  endtask

  function automatic logic [31:0] exp_word(input int c, input int w);
    logic [31:0] t [5];
    t[0] = 1; t[1] = (c == 0) ? 1 : 2; t[2] = 1; t[3] = (c == 2) ? 2 : 1;
    t[4] = t[0] + t[1] + t[2] + t[3];
    return t[w];
  endfunction

  task automatic t_reset;
    check("R12 reset done", 32'(done), 32'd0);
    check("R12 reset status", status, 32'd0);
    check("R14 reset req", 32'(bus_req), 32'd0);
  endtask

  task automatic t_basic(input int c);
    logic [31:0] s;
    setup(0, 0, 1'b0, 1'b0, 32'd1, 32'h1234_0000 + 32'(c));
    pulse_start(3'(c));
    wait_done("basic");
    for (int w = 0; w < 5; w++) check("R4 message word", host_msg[w], exp_word(c, w));
    check("R4 message writes", 32'(n_msg_wr), 32'd5);
    check("R5 doorbell writes", 32'(n_door), 32'd1);
    check("R9 release writes", 32'(n_clr), 32'd1);
    check("R9 last access is release", {last_we, 7'd0, last_addr, last_wd[11:0]}, {1'b1, 7'd0, 12'h014, 12'h000});
    check("R11 success status", status, 32'd1);
    s = 32'd2 + exp_word(c, 1) + 32'd1 + (32'h1234_0000 + 32'(c));
    check("R6 reply w0", reply[31:0], 32'd2);
    check("R6 reply w1", reply[63:32], exp_word(c, 1));
    check("R6 reply w3", reply[127:96], 32'h1234_0000 + 32'(c));
    check("R6 reply w4", reply[159:128], s);
    @(negedge clk);
    check("R12 done one cycle", 32'(done), 32'd0);
    check("R12 status held", status, 32'd1);
  endtask

  task automatic t_delays;
    setup(2, 3, 1'b0, 1'b0, 32'd1, 32'h55);
    pulse_start(3'd1);
    wait_done("delays");
    check("R2 R6 mailbox reads", 32'(n_rd), 32'd7);
    check("R2 message writes after idle", 32'(n_msg_wr), 32'd5);
    check("R6 readback count", 32'(n_readback), 32'd5);
    check("R7 poll spacing ok", 32'(min_gap >= PGAP + 2), 32'd1);
    check("R11 status after delays", status, 32'd1);
  endtask

  task automatic t_reject(input logic [2:0] i);
    setup(0, 0, 1'b0, 1'b0, 32'd1, 32'h0);
    pulse_start(i);
    check("R1 reject done", 32'(done), 32'd1);
    check("R1 reject status", status, 32'h8000_0002);
    check("R1 reject reply zero", reply[31:0] | reply[159:128], 32'd0);
    @(negedge clk);
    check("R1 reject no bus", 32'(n_acc), 32'd0);
    check("R12 reject pulse ends", 32'(done), 32'd0);
  endtask

  task automatic t_chksum;
    setup(0, 1, 1'b0, 1'b1, 32'd1, 32'h9);
    pulse_start(3'd2);
    wait_done("chksum");
    check("R10 checksum status", status, 32'h8000_0004);
    check("R10 reply w4 kept", reply[159:128], 32'd2 + 32'd2 + 32'd1 + 32'h9 + 32'd1);
  endtask

  task automatic t_errcode;
    setup(0, 0, 1'b0, 1'b0, 32'h8000_0008, 32'h3);
    pulse_start(3'd0);
    wait_done("errcode");
    check("R11 coprocessor code", status, 32'h8000_0008);
  endtask

  task automatic t_reply_tmo;
    setup(0, 0, 1'b1, 1'b0, 32'd1, 32'h0);
    pulse_start(3'd1);
    wait_done("reply tmo");
    check("R8 timeout status", status, 32'h8000_0010);
    check("R8 no readback", 32'(n_readback), 32'd0);
    check("R8 reply zero", reply[31:0] | reply[63:32] | reply[159:128], 32'd0);
    check("R8 poll count", 32'(n_rd), 32'(1 + PMAX));
    check("R9 release on timeout", 32'(n_clr), 32'd1);
  endtask

  task automatic t_idle_tmo;
    setup(1000000, 0, 1'b0, 1'b0, 32'd1, 32'h0);
    pulse_start(3'd0);
    wait_done("idle tmo");
    check("R3 timeout status", status, 32'h8000_0010);
    check("R3 idle poll count", 32'(n_rd), 32'(PMAX));
    check("R3 no message write", 32'(n_msg_wr), 32'd0);
    check("R3 no doorbell", 32'(n_door), 32'd0);
    check("R3 no release", 32'(n_clr), 32'd0);
  endtask

  task automatic t_busy_start;
    setup(1, 2, 1'b0, 1'b0, 32'd1, 32'h77);
    pulse_start(3'd2);
    repeat (6) @(negedge clk);
    pulse_start(3'd0);
    repeat (4) @(negedge clk);
    pulse_start(3'd5);
    wait_done("busy");
    repeat (3) @(negedge clk);
    for (int w = 0; w < 5; w++) check("R13 running command kept", host_msg[w], exp_word(2, w));
    check("R13 single done", 32'(n_done), 32'd1);
    check("R13 status", status, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_checks + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_basic(0);
    t_basic(1);
    t_basic(2);
    t_delays;
    t_reject(3'd3);
    t_reject(3'd7);
    t_chksum;
    t_errcode;
    t_reply_tmo;
    t_idle_tmo;
    t_busy_start;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule